// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer with Refresh

This block connects a simple synchronous request port to a 16 Mbit DRAM. The DRAM is built as 2048 rows by 2048 columns of 4-bit elements. Each 22-bit word address is split into two halves: an 11-bit row (the upper half) and an 11-bit column (the lower half). The two halves go out one after the other on a shared 11-bit address bus. Two active-low strobes mark them: a row strobe and a column strobe. Active-low write-enable and output-enable lines select the direction of the transfer. Read data is captured while the column strobe is low and comes back to the requester with a one-cycle valid pulse.

The block also keeps the array refreshed. A timer with a programmable interval raises a refresh request. A refresh row counter is then routed onto the address bus through the same multiplexer that carries the access row and column. A row-strobe-only cycle then refreshes that row. Successive refreshes visit the rows in order and wrap around. A pending refresh takes the sequencer at its next idle point, ahead of any waiting access. It never cuts short an access already under way.

The sequencer states are as follows:

- IDLE: waiting.
- ROW: row address driven.
- RAS: row strobe low.
- COL: column address driven under the row strobe.
- CAS: both strobes low.
- PRE: precharge, both strobes high.
- RROW: refresh row address driven.
- RRAS: refresh row strobe low.

The transitions are as follows:

- IDLE goes to RROW on a pending refresh.
- Otherwise, IDLE goes to ROW on a request.
- The access path runs ROW to RAS to COL to CAS to PRE.
- The refresh path runs RROW to RRAS to PRE.
- PRE returns to IDLE.
- Every non-idle state lasts its parameterised number of cycles.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, all four strobes (row, column, write, output enable) are high, the data driver is off, and neither `req_ready` nor `rsp_valid` is asserted.
- R2: For an access, the address bus carries `req_addr[21:11]` while the row strobe is falling, and `req_addr[10:0]` while the column strobe is falling.
- R3: For each access, the following widths and gaps hold. The row strobe stays low for RAS_CYC+COL_CYC+CAS_CYC cycles. The column strobe stays low for exactly CAS_CYC cycles, only while the row strobe is low. Between two row-strobe pulses the row strobe stays high for at least PRE_CYC+ROW_CYC cycles.
- R4: A write drives `dram_we_n` low and `dram_oe_n` high during the column strobe. The data driver is enabled with the request's write data only while both strobes are low.
- R5: A read drives `dram_oe_n` low and `dram_we_n` high during the column strobe. It produces exactly one `rsp_valid` pulse, carrying the data present on `dram_dq_in` during the column strobe. A write produces no pulse.
- R6: `req_ready` is asserted for one cycle per accepted request, and only from IDLE. The following cycle it is low even if `req_valid` stays high.
- R7: A refresh is a row-strobe-only pulse of REF_CYC cycles during which the column strobe stays high. The address bus carries the refresh counter value.
- R8: The refresh counter starts at 0 after reset and advances by one after each refresh. It wraps from 2047 back to 0.
- R9: A pending refresh is granted at the next idle point ahead of a waiting request. It is never started inside an access. As a result, under continuous traffic, the spacing between refresh pulses stays within one access length of refresh_interval+1.
- R10: The interval timer counts `refresh_interval`+1 cycles between refresh requests. With no access traffic, the row strobe of successive refreshes falls exactly that many cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_interval | input | 16 | Cycles between refresh requests, minus one |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | One-cycle acknowledge of the request |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| dram_a | output | 11 | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
Two situations are hard to bring about from the ports. The first is a refresh request maturing while an access request is already waiting, or while an access is mid-sequence. The bench reaches it by issuing randomised reads and writes back to back, so a request is nearly always pending when the interval timer fires. It then bounds every refresh spacing, and checks each access's strobe widths to show that nothing was cut short. The second is the counter wrap, which takes 2048 refreshes. A short interval and a long idle stretch carry the expected row past 2047 and back to 0.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE,
        ST_RROW,
        ST_RRAS
    } seq_state_e;

    // Address bus source
    typedef enum logic [1:0] {
        SEL_ROW,
        SEL_COL,
        SEL_REF
    } addr_sel_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval,
    input  logic          grant,
    output logic          pend
);

    logic [IW-1:0] cnt_q;
    logic          pend_q;
    logic          fire;

    assign fire = (cnt_q >= interval);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (fire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fire) begin
                pend_q <= 1'b1;
            end else if (grant) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !grant) |=> pend);

endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
    parameter int RW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump,
    output logic [RW-1:0] row
);

    logic [RW-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (bump) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row = row_q;

    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(row));

    // R8
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && (row == {RW{1'b1}})) |=> (row == '0));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int RW = 11,
    parameter int CW = 11,
    parameter int PW = 11
) (
    input  addr_sel_e     sel,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] ref_row,
    output logic [PW-1:0] a
);

    always_comb begin
        unique case (sel)
            SEL_ROW: a = PW'(row);
            SEL_COL: a = PW'(col);
            SEL_REF: a = PW'(ref_row);
            default: a = '0;
        endcase
    end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_ctrl_pkg::*;
#(
    parameter int RW      = 11,
    parameter int CW      = 11,
    parameter int DW      = 4,
    parameter int ROW_CYC = 1,
    parameter int RAS_CYC = 2,
    parameter int COL_CYC = 1,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2,
    parameter int REF_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [RW+CW-1:0] req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             ref_pend,
    output logic             req_ready,
    output logic             ref_grant,
    output logic             ref_bump,
    output addr_sel_e        sel,
    output logic [RW-1:0]    row_addr,
    output logic [CW-1:0]    col_addr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata
);

    localparam int AW   = RW + CW;
    localparam int MA   = (ROW_CYC > RAS_CYC) ? ROW_CYC : RAS_CYC;
    localparam int MB   = (COL_CYC > CAS_CYC) ? COL_CYC : CAS_CYC;
    localparam int MC   = (PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC;
    localparam int MAB  = (MA > MB) ? MA : MB;
    localparam int MAXC = (MAB > MC) ? MAB : MC;
    localparam int TW   = $clog2(MAXC + 1);

    seq_state_e      state_q, state_d;
    logic [TW-1:0]   cnt_q;
    logic            phase_done;
    logic            accept, grant, bump;
    logic [RW-1:0]   row_q;
    logic [CW-1:0]   col_q;
    logic [DW-1:0]   wdata_q;
    logic            write_q;
    logic            rsp_valid_q;
    logic [DW-1:0]   rdata_q;

    // Cycles left in a phase after the entry cycle
    function automatic logic [TW-1:0] phase_len(seq_state_e s);
        case (s)
            ST_ROW, ST_RROW: return TW'(ROW_CYC - 1);
            ST_RAS:          return TW'(RAS_CYC - 1);
            ST_COL:          return TW'(COL_CYC - 1);
            ST_CAS:          return TW'(CAS_CYC - 1);
            ST_PRE:          return TW'(PRE_CYC - 1);
            ST_RRAS:         return TW'(REF_CYC - 1);
            default:         return '0;
        endcase
    endfunction

    assign phase_done = (cnt_q == '0);

    // Next state and arbitration
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        grant   = 1'b0;
        bump    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    state_d = ST_RROW;
                    grant   = 1'b1;
                end else if (req_valid) begin
                    state_d = ST_ROW;
                    accept  = 1'b1;
                end
            end
            ST_ROW:  if (phase_done) state_d = ST_RAS;
            ST_RAS:  if (phase_done) state_d = ST_COL;
            ST_COL:  if (phase_done) state_d = ST_CAS;
            ST_CAS:  if (phase_done) state_d = ST_PRE;
            ST_PRE:  if (phase_done) state_d = ST_IDLE;
            ST_RROW: if (phase_done) state_d = ST_RRAS;
            ST_RRAS: begin
                if (phase_done) begin
                    state_d = ST_PRE;
                    bump    = 1'b1;
                end
            end
        endcase
    end

    // State register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= phase_len(state_d);
            end else if (!phase_done) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            row_q   <= req_addr[AW-1:CW];
            col_q   <= req_addr[CW-1:0];
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // Read capture on the last column-strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= (state_q == ST_CAS) && phase_done && !write_q;
            if ((state_q == ST_CAS) && phase_done && !write_q) begin
                rdata_q <= dq_in;
            end
        end
    end

    // Pin decode
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        sel   = SEL_ROW;
        unique case (state_q)
            ST_IDLE, ST_PRE, ST_ROW: begin
                sel = SEL_ROW;
            end
            ST_RAS: begin
                ras_n = 1'b0;
            end
            ST_COL: begin
                ras_n = 1'b0;
                sel   = SEL_COL;
            end
            ST_CAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                sel   = SEL_COL;
                we_n  = !write_q;
                oe_n  = write_q;
                dq_oe = write_q;
            end
            ST_RROW: begin
                sel = SEL_REF;
            end
            ST_RRAS: begin
                ras_n = 1'b0;
                sel   = SEL_REF;
            end
        endcase
    end

    assign req_ready = accept;
    assign ref_grant = grant;
    assign ref_bump  = bump;
    assign row_addr  = row_q;
    assign col_addr  = col_q;
    assign dq_out    = wdata_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rdata_q;

    // R3
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R4
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !cas_n && !ras_n));

    // R5
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!cas_n && !oe_n));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R9
    ack_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ref_pend);

    // R7
    refresh_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_REF) |-> cas_n);

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_BITS  = 11,
    parameter int COL_BITS  = 11,
    parameter int DATA_BITS = 4,
    parameter int IVL_BITS  = 16,
    parameter int ROW_CYC   = 1,
    parameter int RAS_CYC   = 2,
    parameter int COL_CYC   = 1,
    parameter int CAS_CYC   = 2,
    parameter int PRE_CYC   = 2,
    parameter int REF_CYC   = 3,
    localparam int ADDR_BITS = ROW_BITS + COL_BITS,
    localparam int PIN_BITS  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IVL_BITS-1:0]  refresh_interval,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [DATA_BITS-1:0] req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [DATA_BITS-1:0] rsp_rdata,
    output logic [PIN_BITS-1:0]  dram_a,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DATA_BITS-1:0] dram_dq_out,
    output logic                 dram_dq_oe,
    input  logic [DATA_BITS-1:0] dram_dq_in
);

    logic                ref_pend, ref_grant, ref_bump;
    logic [ROW_BITS-1:0] ref_row;
    logic [ROW_BITS-1:0] acc_row;
    logic [COL_BITS-1:0] acc_col;
    addr_sel_e           addr_sel;

    dram_ref_timer #(.IW(IVL_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (refresh_interval),
        .grant    (ref_grant),
        .pend     (ref_pend)
    );

    dram_ref_row #(.RW(ROW_BITS)) u_ref_row (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (ref_bump),
        .row   (ref_row)
    );

    dram_seq #(
        .RW      (ROW_BITS),
        .CW      (COL_BITS),
        .DW      (DATA_BITS),
        .ROW_CYC (ROW_CYC),
        .RAS_CYC (RAS_CYC),
        .COL_CYC (COL_CYC),
        .CAS_CYC (CAS_CYC),
        .PRE_CYC (PRE_CYC),
        .REF_CYC (REF_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ref_pend  (ref_pend),
        .req_ready (req_ready),
        .ref_grant (ref_grant),
        .ref_bump  (ref_bump),
        .sel       (addr_sel),
        .row_addr  (acc_row),
        .col_addr  (acc_col),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .dq_out    (dram_dq_out),
        .dq_oe     (dram_dq_oe),
        .dq_in     (dram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    dram_addr_mux #(
        .RW (ROW_BITS),
        .CW (COL_BITS),
        .PW (PIN_BITS)
    ) u_amux (
        .sel     (addr_sel),
        .row     (acc_row),
        .col     (acc_col),
        .ref_row (ref_row),
        .a       (dram_a)
    );

endmodule

// File: tb/tb_dram_ctrl.sv
`timescale 1ns/1ps
module tb_dram_ctrl;

    localparam int T_ROW = 1;
    localparam int T_RAS = 2;
    localparam int T_COL = 1;
    localparam int T_CAS = 2;
    localparam int T_PRE = 2;
    localparam int T_REF = 3;
    localparam int ACC_LEN  = T_ROW + T_RAS + T_COL + T_CAS + T_PRE;
    localparam int INTERVAL = 40;
    localparam int NROWS    = 2048;

    typedef struct {
        bit        wr;
        bit [21:0] addr;
        bit [3:0]  data;
    } op_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] refresh_interval;
    logic        req_valid, req_write;
    logic [21:0] req_addr;
    logic [3:0]  req_wdata;
    logic        req_ready, rsp_valid;
    logic [3:0]  rsp_rdata;
    logic [10:0] dram_a;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dram_dq_in = 4'h0;

    always #2.5 clk = ~clk;

    dram_ctrl #(
        .ROW_CYC (T_ROW), .RAS_CYC (T_RAS), .COL_CYC (T_COL),
        .CAS_CYC (T_CAS), .PRE_CYC (T_PRE), .REF_CYC (T_REF)
    ) dut (
        .clk (clk), .rst_n (rst_n), .refresh_interval (refresh_interval),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_ready (req_ready), .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata), .dram_a (dram_a), .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench state
    bit [3:0]  mem    [bit [21:0]];
    bit [3:0]  shadow [bit [21:0]];
    op_t       opq[$];
    bit        ras_prev = 1'b1, cas_prev = 1'b1;
    bit [10:0] m_row;
    bit [10:0] fall_row;
    int        ras_low = 0, cas_low = 0, ras_high = 0;
    bit        cas_seen = 1'b0, got_rsp = 1'b0, seen_pulse = 1'b0;
    int        exp_ref = 0, n_ref = 0;
    longint    cyc = 0, fall_cyc = 0, prev_ref_fall = 0;
    bit        have_prev_ref = 1'b0, acc_in_gap = 1'b0, acc_in_prev_gap = 1'b0;

    // DRAM model and pin monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!dram_ras_n && ras_prev) m_row = dram_a;
            if (!dram_ras_n && !dram_cas_n && !dram_we_n) mem[{m_row, dram_a}] = dram_dq_out;
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n && mem.exists({m_row, dram_a}))
                dram_dq_in = mem[{m_row, dram_a}];
            else
                dram_dq_in = 4'h0;

            if (!dram_ras_n && ras_prev) begin
                // R3 precharge plus row setup before each row strobe
                if (seen_pulse) chk(ras_high >= T_PRE + T_ROW, "R3 ras high time", ras_high, T_PRE + T_ROW);
                fall_row = dram_a;
                fall_cyc = cyc;
                ras_low  = 0;
                cas_seen = 1'b0;
            end
            if (!dram_cas_n && cas_prev) begin
                cas_seen = 1'b1;
                cas_low  = 0;
                chk(opq.size() > 0, "R2 access with request queued", opq.size(), 1);
                if (opq.size() > 0) begin
                    chk(dram_a == opq[0].addr[10:0], "R2 column on bus", dram_a, opq[0].addr[10:0]);
                    if (opq[0].wr) begin
                        chk(!dram_we_n && dram_oe_n && dram_dq_oe, "R4 write controls",
                            {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b011);
                        chk(dram_dq_out == opq[0].data, "R4 write data", dram_dq_out, opq[0].data);
                    end else begin
                        chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R5 read controls",
                            {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b100);
                    end
                end
            end
            if (!dram_cas_n) cas_low++;
            if (!dram_ras_n) ras_low++; else ras_high++;
            if (dram_cas_n && !cas_prev) chk(cas_low == T_CAS, "R3 cas width", cas_low, T_CAS);

            if (rsp_valid) begin
                if (opq.size() > 0 && !opq[0].wr && !got_rsp) begin
                    chk(rsp_rdata == opq[0].data, "R5 read data", rsp_rdata, opq[0].data);
                    got_rsp = 1'b1;
                end else begin
                    chk(1'b0, "R5 unexpected response", 1, 0);
                end
            end

            if (dram_ras_n && !ras_prev) begin
                seen_pulse = 1'b1;
                ras_high   = 0;
                if (cas_seen) begin
                    if (opq.size() > 0) begin
                        chk(fall_row == opq[0].addr[21:11], "R2 row on bus", fall_row, opq[0].addr[21:11]);
                        chk(ras_low == T_RAS + T_COL + T_CAS, "R3 ras width", ras_low, T_RAS + T_COL + T_CAS);
                        if (!opq[0].wr) chk(got_rsp, "R5 one response per read", got_rsp, 1);
                        void'(opq.pop_front());
                    end
                    got_rsp    = 1'b0;
                    acc_in_gap = 1'b1;
                end else begin
                    // R7 and R8: refresh row follows the counter, wrapping at 2047
                    chk(fall_row == exp_ref[10:0], "R8 refresh row", fall_row, exp_ref);
                    chk(ras_low == T_REF, "R7 refresh ras width", ras_low, T_REF);
                    exp_ref = (exp_ref + 1) % NROWS;
                    n_ref++;
                    if (have_prev_ref) begin
                        if (!acc_in_gap && !acc_in_prev_gap)
                            chk(fall_cyc - prev_ref_fall == INTERVAL + 1, "R10 refresh spacing",
                                fall_cyc - prev_ref_fall, INTERVAL + 1);
                        else
                            chk((fall_cyc - prev_ref_fall <= INTERVAL + 1 + ACC_LEN) &&
                                (fall_cyc - prev_ref_fall >= INTERVAL + 1 - ACC_LEN),
                                "R9 refresh spacing under traffic", fall_cyc - prev_ref_fall, INTERVAL + 1);
                    end
                    have_prev_ref   = 1'b1;
                    prev_ref_fall   = fall_cyc;
                    acc_in_prev_gap = acc_in_gap;
                    acc_in_gap      = 1'b0;
                end
            end
            ras_prev = dram_ras_n;
            cas_prev = dram_cas_n;
        end
    end

    // Request driver, called at a falling edge
    task automatic issue(input bit wr, input bit [21:0] a, input bit [3:0] d);
        op_t o;
        bit  done = 1'b0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!done) begin
            #1;
            if (req_ready) begin
                o.wr   = wr;
                o.addr = a;
                o.data = wr ? d : (shadow.exists(a) ? shadow[a] : 4'h0);
                if (wr) shadow[a] = d;
                opq.push_back(o);
                @(negedge clk);
                #1;
                chk(!req_ready, "R6 ready is a single pulse", req_ready, 0);
                done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic reset_checks(input string tag);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, {"R1 strobes high ", tag},
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dram_dq_oe && !req_ready && !rsp_valid, {"R1 outputs idle ", tag},
            {dram_dq_oe, req_ready, rsp_valid}, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", 190000);
        finish_run();
    end

    bit [21:0] pool [16];

    initial begin
        void'($urandom(32'h5EED_0D1A));
        rst_n            = 1'b0;
        req_valid        = 1'b0;
        req_write        = 1'b0;
        req_addr         = '0;
        req_wdata        = '0;
        refresh_interval = 16'(INTERVAL);
        repeat (3) @(negedge clk);
        reset_checks("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("after reset");

        // R10 quiet spacing
        while (n_ref < 5) @(negedge clk);

        // Directed corners: extremes of row and column (R2, R4, R5)
        issue(1'b1, 22'h000000, 4'h5);
        issue(1'b1, 22'h3FFFFF, 4'hA);
        issue(1'b1, {11'h7FF, 11'h000}, 4'h3);
        issue(1'b1, {11'h000, 11'h7FF}, 4'hC);
        issue(1'b0, 22'h000000, 4'h0);
        issue(1'b0, 22'h3FFFFF, 4'h0);
        issue(1'b0, {11'h7FF, 11'h000}, 4'h0);
        issue(1'b0, {11'h000, 11'h7FF}, 4'h0);
        issue(1'b0, 22'h155555, 4'h0);

        pool[0] = 22'h000000;
        pool[1] = 22'h3FFFFF;
        for (int i = 2; i < 16; i++) pool[i] = 22'($urandom);

        // Saturated random traffic: refresh requests meet waiting accesses (R9)
        for (int i = 0; i < 1500; i++) begin
            issue(1'($urandom), pool[$urandom % 16], 4'($urandom));
        end

        // Idle until the refresh counter wraps (R8)
        while (n_ref < NROWS + 4) @(negedge clk);
        chk(opq.size() == 0, "R5 all accesses completed", opq.size(), 0);
        chk(n_ref > NROWS, "R8 counter wrapped past 2047", n_ref, NROWS + 1);
        finish_run();
    end

endmodule